// File: doc/BRIEF.md
# FIFO DMA Request Controller

This block raises level-triggered demand requests toward an external DMA controller for one channel's transmit and receive FIFOs. It also turns bus strobes into FIFO push and pop pulses. The FIFO storage and the framing logic sit outside it. The block sees the fill levels as inputs: free space for transmit and stored bytes for receive.

On transmit, software first programs a 16-bit byte count. The block then requests writes in blocks of up to 64 bytes. Each block is as large as the remaining count allows. A block starts only when the FIFO has room for all of it. The request falls right after the last write of a block.

On receive, the request rises when the FIFO holds a full block of the configured threshold size (64, 32, 16, 8 or 4 bytes). It falls right after the last read of that block.

While the acknowledge input is low, a strobe reaches the FIFO directly. The address is ignored and chip select is not needed.

Each `wr_i` or `rd_i` pulse is one clock wide. It marks the start of a bus cycle, that is, the falling edge of the host strobe.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset the control register is zero and DMA is disabled. No request rises until control bit 0 (DMA enable) is set.
- R2: A write with `cs_ni` low and `dack_ni` high stores the byte count in two registers. Address 0x10 holds the low byte. Address 0x11 holds the high byte, and writing it loads the remaining count as {high, low}.
- R3: A transmit block has size min(64, remaining). `drq_tx_o` rises only when DMA is enabled, the remaining count is nonzero, and `tx_free_i` is at least the block size.
- R4: `drq_tx_o` is low in the clock cycle after the cycle in which the last write of a block is sampled. The total number of writes over all blocks equals the programmed count.
- R5: Once the remaining count is zero, `drq_tx_o` stays low until a new count is loaded.
- R6: Control bits [3:1] select the receive block size: 0 gives 64, 1 gives 32, 2 gives 16, 3 gives 8, and 4 to 7 give 4. `drq_rx_o` rises only when DMA is enabled and `rx_fill_i` is at least that size.
- R7: `drq_rx_o` is low in the clock cycle after the last read of a receive block is sampled. Each receive block contains exactly the selected size in reads.
- R8: With `dack_ni` low, `wr_i` pushes the transmit FIFO and `rd_i` pops the receive FIFO. `addr_i` and `cs_ni` have no effect, and no register is written.
- R9: A strobe with both `dack_ni` and `cs_ni` high produces no push and no pop.
- R10: With `cs_ni` low and `addr_i` = 0x00, a strobe also pushes or pops the FIFO. A write to any other register address does not push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select for addressed accesses |
| dack_ni | input | 1 | Active-low DMA acknowledge; selects the FIFO |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data for registers |
| wr_i | input | 1 | Write strobe start pulse |
| rd_i | input | 1 | Read strobe start pulse |
| tx_free_i | input | 7 | Free bytes in the transmit FIFO |
| rx_fill_i | input | 7 | Stored bytes in the receive FIFO |
| drq_tx_o | output | 1 | Transmit DMA request |
| drq_rx_o | output | 1 | Receive DMA request |
| tx_push_o | output | 1 | Push one byte into the transmit FIFO |
| rx_pop_o | output | 1 | Pop one byte from the receive FIFO |

## Verification
The hardest case to reach is the end of a transfer. Several full blocks must run, and then the short remainder block, with the request dropping exactly on the last write and never rising again.

The stimulus covers this with two byte counts, 150 and 261. A model DMA engine answers every request cycle with an acknowledged write. The FIFO model drains slowly, so each new block must also wait for free space.

During acknowledged writes the engine drives the control register's address with zero data. A design that decoded the address under acknowledge would therefore disable itself mid-transfer.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef struct packed {
    logic [2:0] thr;
    logic       en;
  } ctrl_t;

  // receive block size: blk_max >> code, floored at 4 bytes
  function automatic int unsigned rx_blk_size(int unsigned blk_max, logic [2:0] code);
    int unsigned max_sh;
    int unsigned sh;
    max_sh = $clog2(blk_max) - 2;
    sh = (int'(code) > max_sh) ? max_sh : int'(code);
    return blk_max >> sh;
  endfunction

endpackage

// File: rtl/dma_host_decode.sv
module dma_host_decode #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] FIFO_ADDR   = 'h00,
  parameter logic [ADDR_W-1:0] CNT_LO_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] CNT_HI_ADDR = 'h11,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 dack_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic                 push_o,
  output logic                 pop_o,
  output dma_req_pkg::ctrl_t   ctrl_o,
  output logic                 cnt_load_o,
  output logic [CNT_W-1:0]     cnt_val_o
);
  logic [CNT_W-9:0] cnt_lo_q;
  logic fifo_sel, reg_wr;

  // acknowledge overrides chip select and address
  assign fifo_sel = !dack_ni || (!cs_ni && addr_i == FIFO_ADDR);
  assign reg_wr   = wr_i && dack_ni && !cs_ni;
  assign push_o   = wr_i && fifo_sel;
  assign pop_o    = rd_i && fifo_sel;

  assign cnt_load_o = reg_wr && addr_i == CNT_HI_ADDR;
  assign cnt_val_o  = {wdata_i, cnt_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0;
      ctrl_o   <= '0;
    end else if (reg_wr) begin
      if (addr_i == CNT_LO_ADDR) cnt_lo_q <= wdata_i[CNT_W-9:0];
      if (addr_i == CTRL_ADDR)   ctrl_o   <= dma_req_pkg::ctrl_t'(wdata_i[3:0]);
    end
  end

  assert_ignored_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && dack_ni && cs_ni) |-> (!push_o && !pop_o));
  assert_dack_no_reg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_ni |=> $stable(ctrl_o));
endmodule

// File: rtl/dma_tx_req.sv
module dma_tx_req #(
  parameter int CNT_W   = 16,
  parameter int BLK_MAX = 64,
  parameter int LVL_W   = $clog2(BLK_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              push_i,
  input  logic [LVL_W-1:0]  free_i,
  output logic              drq_o
);
  localparam int BLK_W = $clog2(BLK_MAX + 1);

  logic [CNT_W-1:0] remain_q;
  logic [BLK_W-1:0] blk_q, blk_size;
  logic             active_q;

  assign blk_size = (remain_q > CNT_W'(BLK_MAX)) ? BLK_W'(BLK_MAX) : BLK_W'(remain_q);
  assign drq_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      blk_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      remain_q <= load_val_i;
      blk_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (push_i && en_i && remain_q != '0) remain_q <= remain_q - 1'b1;
      if (!en_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (push_i) begin
          blk_q <= blk_q - 1'b1;
          if (blk_q == BLK_W'(1)) active_q <= 1'b0;
        end
      end else if (remain_q != '0 && LVL_W'(blk_size) <= free_i) begin
        active_q <= 1'b1;
        blk_q    <= blk_size;
      end
    end
  end

  assert_tx_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && push_i && blk_q == BLK_W'(1) && !load_i) |=> !drq_o);
  assert_tx_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q == '0 && !active_q) |=> !drq_o);
  assert_tx_room_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> LVL_W'(blk_q) <= $past(free_i));
  assert_tx_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drq_o) |-> $past(en_i));
endmodule

// File: rtl/dma_rx_req.sv
module dma_rx_req #(
  parameter int BLK_MAX = 64,
  parameter int LVL_W   = $clog2(BLK_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       thr_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] fill_i,
  output logic             drq_o
);
  localparam int BLK_W = $clog2(BLK_MAX + 1);

  logic [BLK_W-1:0] blk_q, blk_size;
  logic             active_q;

  assign blk_size = BLK_W'(dma_req_pkg::rx_blk_size(BLK_MAX, thr_i));
  assign drq_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q    <= '0;
      active_q <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (pop_i) begin
        blk_q <= blk_q - 1'b1;
        if (blk_q == BLK_W'(1)) active_q <= 1'b0;
      end
    end else if (LVL_W'(blk_size) <= fill_i) begin
      active_q <= 1'b1;
      blk_q    <= blk_size;
    end
  end

  assert_rx_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && pop_i && blk_q == BLK_W'(1)) |=> !drq_o);
  assert_rx_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> LVL_W'(blk_q) <= $past(fill_i));
  assert_rx_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drq_o) |-> $past(en_i));
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int BLK_MAX = 64,
  parameter int LVL_W   = $clog2(BLK_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              dack_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [LVL_W-1:0]  tx_free_i,
  input  logic [LVL_W-1:0]  rx_fill_i,
  output logic              drq_tx_o,
  output logic              drq_rx_o,
  output logic              tx_push_o,
  output logic              rx_pop_o
);
  dma_req_pkg::ctrl_t ctrl;
  logic               cnt_load;
  logic [CNT_W-1:0]   cnt_val;

  dma_host_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_decode (
    .clk_i, .rst_ni, .cs_ni, .dack_ni, .addr_i, .wdata_i, .wr_i, .rd_i,
    .push_o(tx_push_o), .pop_o(rx_pop_o), .ctrl_o(ctrl),
    .cnt_load_o(cnt_load), .cnt_val_o(cnt_val)
  );

  dma_tx_req #(.CNT_W(CNT_W), .BLK_MAX(BLK_MAX), .LVL_W(LVL_W)) i_tx (
    .clk_i, .rst_ni, .en_i(ctrl.en), .load_i(cnt_load), .load_val_i(cnt_val),
    .push_i(tx_push_o), .free_i(tx_free_i), .drq_o(drq_tx_o)
  );

  dma_rx_req #(.BLK_MAX(BLK_MAX), .LVL_W(LVL_W)) i_rx (
    .clk_i, .rst_ni, .en_i(ctrl.en), .thr_i(ctrl.thr), .pop_i(rx_pop_o),
    .fill_i(rx_fill_i), .drq_o(drq_rx_o)
  );
endmodule

// File: tb/test_dma_req_ctrl.sv
module test_dma_req_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic h_cs_n = 1'b1, h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0] h_addr = '0, h_wdata = '0;
  logic e_ack = 1'b0, e_wr = 1'b0, e_rd = 1'b0;
  logic cs_n, dack_n, wr, rd;
  logic [7:0] addr, wdata;
  logic [6:0] tx_free, rx_fill;
  logic drq_tx, drq_rx, tx_push, rx_pop;
  int tx_free_m = 64, rx_fill_m = 0, rx_add = 0;
  int n_chk = 0, n_fail = 0;
  int exp_tx[$], exp_rx[$];

  assign cs_n = h_cs_n;
  assign dack_n = ~e_ack;
  assign addr = e_ack ? 8'h12 : h_addr;   // R8: control address under acknowledge
  assign wdata = e_ack ? 8'h00 : h_wdata;
  assign wr = h_wr | e_wr;
  assign rd = h_rd | e_rd;
  assign tx_free = 7'(tx_free_m);
  assign rx_fill = 7'(rx_fill_m);

  dma_req_ctrl i_dma_req_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .dack_ni(dack_n), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .tx_free_i(tx_free), .rx_fill_i(rx_fill),
    .drq_tx_o(drq_tx), .drq_rx_o(drq_rx), .tx_push_o(tx_push), .rx_pop_o(rx_pop)
  );

  always @(posedge clk) begin
    if (tx_push) tx_free_m <= tx_free_m - 1;
    else if (!drq_tx && tx_free_m < 64) tx_free_m <= tx_free_m + 1;
    rx_fill_m <= rx_fill_m - (rx_pop ? 1 : 0) + rx_add;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // DMA engine: answers every request cycle with an acknowledged access
  initial forever begin
    @(negedge clk);
    e_wr = 1'b0; e_rd = 1'b0; e_ack = 1'b0;
    if (drq_rx) begin e_rd = 1'b1; e_ack = 1'b1; end
    else if (drq_tx) begin e_wr = 1'b1; e_ack = 1'b1; end
  end

  // transmit monitor: R3 R4 block sizes and room
  initial begin
    int cnt = 0;
    logic prev = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (drq_tx && !prev) begin
        if (exp_tx.size() == 0) check("R5 unexpected tx block", 1, 0);
        else check("R3 tx room at start", int'(tx_free_m >= exp_tx[0]), 1);
      end
      if (drq_tx && tx_push) cnt++;
      if (!drq_tx && prev && exp_tx.size() != 0) begin
        check("R4 tx block length", cnt, exp_tx.pop_front());
        cnt = 0;
      end
      prev = drq_tx;
    end
  end

  // receive monitor: R6 R7 block sizes
  initial begin
    int cnt = 0;
    logic prev = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (drq_rx && !prev && exp_rx.size() == 0) check("R6 unexpected rx block", 1, 0);
      if (drq_rx && rx_pop) cnt++;
      if (!drq_rx && prev && exp_rx.size() != 0) begin
        check("R7 rx block length", cnt, exp_rx.pop_front());
        cnt = 0;
      end
      prev = drq_rx;
    end
  end

  task automatic host_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    h_cs_n = 1'b0; h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk);
    h_cs_n = 1'b1; h_wr = 1'b0;
  endtask

  task automatic add_rx(int n);
    @(negedge clk); rx_add = n;
    @(negedge clk); rx_add = 0;
  endtask

  task automatic wait_drain(string req);
    int t = 0;
    while ((exp_tx.size() != 0 || exp_rx.size() != 0 || drq_tx || drq_rx) && t < 5000) begin
      @(negedge clk); t++;
    end
    check(req, int'(t < 5000), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_check(string req, int cycles);
    int seen = 0;
    repeat (cycles) begin @(negedge clk); #2; if (drq_tx || drq_rx) seen = 1; end
    check(req, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset drq_tx", int'(drq_tx), 0);
    check("R1 reset drq_rx", int'(drq_rx), 0);
    rst_n = 1'b1;

    // R9: strobes without select do nothing
    @(negedge clk); h_wr = 1'b1; h_addr = 8'h00; #2;
    check("R9 ignored write push", int'(tx_push), 0);
    h_wr = 1'b0; h_rd = 1'b1; #1;
    check("R9 ignored read pop", int'(rx_pop), 0);
    h_rd = 1'b0;

    // R1: count loaded but DMA disabled
    host_wr(8'h10, 8'd150);
    host_wr(8'h11, 8'h00);
    idle_check("R1 no request while disabled", 30);

    // R2 R3 R4: 150 = 64 + 64 + 22
    exp_tx.push_back(64); exp_tx.push_back(64); exp_tx.push_back(22);
    host_wr(8'h12, 8'h05);  // en, rx size code 2
    wait_drain("R4 tx 150 completes");
    idle_check("R5 no tx request after count used up", 100);

    // R2: 0x0105 = 261 = 4*64 + 5
    for (int i = 0; i < 4; i++) exp_tx.push_back(64);
    exp_tx.push_back(5);
    host_wr(8'h10, 8'h05);
    host_wr(8'h11, 8'h01);
    wait_drain("R2 tx 261 completes");
    idle_check("R5 idle after second count", 40);

    // R6 R7: code 2 -> 16; 40 bytes give two blocks, 8 stay
    exp_rx.push_back(16); exp_rx.push_back(16);
    add_rx(40);
    wait_drain("R7 rx 16-byte blocks");
    idle_check("R6 below threshold no rx request", 20);
    exp_rx.push_back(8);
    host_wr(8'h12, 8'h07);  // code 3 -> 8
    wait_drain("R6 rx code 3");
    exp_rx.push_back(4);
    host_wr(8'h12, 8'h0F);  // code 7 -> 4
    add_rx(4);
    wait_drain("R6 rx code 7");
    host_wr(8'h12, 8'h01);  // code 0 -> 64
    add_rx(63);
    idle_check("R6 63 bytes under 64 threshold", 20);
    exp_rx.push_back(64);
    add_rx(1);
    wait_drain("R6 rx code 0");
    check("R8 rx fill after DMA reads", rx_fill_m, 0);

    // R10: addressed FIFO access with DMA disabled
    host_wr(8'h12, 8'h00);
    @(negedge clk); h_cs_n = 1'b0; h_addr = 8'h00; h_wr = 1'b1; #2;
    check("R10 addressed write push", int'(tx_push), 1);
    h_wr = 1'b0; h_rd = 1'b1; #1;
    check("R10 addressed read pop", int'(rx_pop), 1);
    h_rd = 1'b0; h_addr = 8'h12; h_wr = 1'b1; #1;
    check("R10 register write no push", int'(tx_push), 0);
    @(negedge clk); h_wr = 1'b0; h_cs_n = 1'b1;
    idle_check("R1 disabled after clear", 20);

    check("scoreboard tx empty", exp_tx.size(), 0);
    check("scoreboard rx empty", exp_rx.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule